// File: doc/BRIEF.md
# Descriptor-Table Bus-Master DMA Engine

This engine carries out the memory side of a sector transfer for a disk protocol engine. When it gets a start pulse, it takes the address of a descriptor table in host memory, a transfer direction, a sector count and a starting sector number. It then fetches the 8-byte descriptors from that table one after another. Each descriptor gives a region of memory, and the engine cuts that region into memory bursts. No burst runs past a page boundary.

The memory port can refuse a request by raising busy. The engine does not hold the request and wait. It drops the request, waits a fixed number of cycles and then issues the same request again. The engine keeps count of the command bytes still owed and of the current sector number. A descriptor that ends the table, or an abort, finishes the command with a one-cycle done pulse. The error flag is valid in that same cycle.

The direction is named from the disk's point of view. A transfer that writes to the disk reads from memory, and a transfer that reads from the disk writes to memory.

Top module: `prd_dma_engine`

## Requirements
- R1: A start pulse is taken only while the engine is idle, and taking it raises `busy_o` on the next cycle. The descriptor pointer is loaded from `table_base_i` with bits 1:0 forced to zero. A start pulse that arrives while busy changes nothing.
- R2: Each descriptor is fetched as one request with `mem_desc_o`=1 and `mem_len_o`=8. The first fetch goes to the table pointer, and every accepted fetch moves the pointer on by 8. The reply on `mem_rdata_i` is laid out as base address in [31:0], byte count in [47:32] and end-of-table flag in bit 63.
- R3: A data burst starts where the previous burst of the same descriptor ended, or at the descriptor base for the first burst. Its length is the smallest of three values: the bytes the descriptor still holds, PAGE_BYTES, and the distance to the next PAGE_BYTES boundary.
- R4: When a request meets `mem_busy_i`=1, `mem_req_o` stays low for exactly BACKOFF cycles. The same request is then raised again.
- R5: Descriptor fetches are always memory reads (`mem_we_o`=0). Data bursts have `mem_we_o`=0 when `to_disk_i` was 1 at start, and 1 otherwise.
- R6: The command owes `nsec_i`×512 bytes, and an `nsec_i` of 0 means 256 sectors. `sector_o` starts at `lba_i` and advances by one for every 512 bytes moved.
- R7: The command finishes when the bursts of an end-of-table descriptor are complete. `done_o` is then high for one cycle and `busy_o` drops. `err_o` is 0 if no command bytes remain owed, and 1 otherwise.
- R8: A descriptor whose byte count exceeds the command bytes still owed ends the command with `done_o` and `err_o`=1. No burst is issued for that descriptor.
- R9: `abort_i` while busy ends the command with `done_o` and `err_o`=1 on the next cycle, and no request is issued after that. `abort_i` while idle has no effect.
- R10: After reset the engine is idle with `busy_o`, `done_o` and `mem_req_o` all low.
- R11: A descriptor with a byte count of zero moves no data, and the walk continues with the next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a command |
| table_base_i | input | 32 | Address of the descriptor table |
| to_disk_i | input | 1 | 1 = disk write (memory read), 0 = disk read (memory write) |
| nsec_i | input | 8 | Sector count of the command, 0 means 256 |
| lba_i | input | SEC_W | First sector number |
| abort_i | input | 1 | Abort the running command |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle end-of-command pulse |
| err_o | output | 1 | Error status, valid with done_o |
| sector_o | output | SEC_W | Current sector number |
| mem_req_o | output | 1 | Memory request |
| mem_desc_o | output | 1 | Request is a descriptor fetch |
| mem_we_o | output | 1 | Request writes memory |
| mem_addr_o | output | 32 | Request byte address |
| mem_len_o | output | LEN_W | Request length in bytes |
| mem_busy_i | input | 1 | Memory refuses the request in this cycle |
| mem_rvalid_i | input | 1 | Descriptor reply is valid |
| mem_rdata_i | input | 64 | Descriptor reply |

## Verification
Directed commands cover the special cases. One uses a region that straddles a page boundary, which shows whether the split is made at the boundary. One uses a sector count of zero, which shows whether it is decoded as 256 sectors. One uses a table base with its low bits set, which shows whether the pointer is aligned. Others exercise a zero-length descriptor, an oversized descriptor and an end-of-table descriptor that arrives too early, and each produces a distinct err_o value and burst count. Randomly split descriptor tables, with randomly refused requests, show whether the back-off gap and the retried address hold at any point of the walk. Abort cases and start pulses given while busy show that the engine ignores input it should ignore.

// File: rtl/prd_dma_pkg.sv
package prd_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_BURST,
        ST_PAUSE
    } dma_state_e;

    localparam int DESC_BYTES   = 8;
    localparam int CNT_W        = 16;
    localparam int SECTOR_BYTES = 512;
    localparam int MAX_SECTORS  = 256;

endpackage

// File: rtl/prd_page_split.sv
module prd_page_split #(
    parameter int PAGE_BYTES = 4096,
    parameter int CNT_W      = 16,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int LEN_W     = OFF_W + 1
) (
    input  logic [31:0]      addr_i,
    input  logic [CNT_W-1:0] left_i,
    output logic [LEN_W-1:0] len_o
);
    logic [LEN_W-1:0] room;
    logic [LEN_W-1:0] cap;

    // distance to the next page boundary
    assign room = LEN_W'(PAGE_BYTES) - {1'b0, addr_i[OFF_W-1:0]};

    generate
        if (CNT_W >= LEN_W) begin : g_wide_count
            assign cap = (left_i > CNT_W'(PAGE_BYTES)) ? LEN_W'(PAGE_BYTES)
                                                      : LEN_W'(left_i);
        end else begin : g_narrow_count
            assign cap = LEN_W'(left_i);
        end
    endgenerate

    assign len_o = (cap < room) ? cap : room;
endmodule

// File: rtl/prd_backoff.sv
module prd_backoff #(
    parameter int CYCLES = 6,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = CW'(CYCLES - 1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine
    import prd_dma_pkg::*;
#(
    parameter int PAGE_BYTES = 4096,
    parameter int BACKOFF    = 6,
    parameter int SEC_W      = 28,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int LEN_W     = OFF_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [31:0]      table_base_i,
    input  logic             to_disk_i,
    input  logic [7:0]       nsec_i,
    input  logic [SEC_W-1:0] lba_i,
    input  logic             abort_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [SEC_W-1:0] sector_o,
    output logic             mem_req_o,
    output logic             mem_desc_o,
    output logic             mem_we_o,
    output logic [31:0]      mem_addr_o,
    output logic [LEN_W-1:0] mem_len_o,
    input  logic             mem_busy_i,
    input  logic             mem_rvalid_i,
    input  logic [63:0]      mem_rdata_i
);
    localparam int SEC_SH = $clog2(SECTOR_BYTES);
    localparam int CMD_W  = $clog2(MAX_SECTORS * SECTOR_BYTES + 1);

    typedef struct packed {
        dma_state_e        st;
        logic              ret_burst;
        logic [31:0]       ptr;
        logic [31:0]       addr;
        logic [CNT_W-1:0]  left;
        logic              eot;
        logic [CMD_W-1:0]  cmd_left;
        logic [SEC_W-1:0]  sector;
        logic [SEC_SH-1:0] frac;
        logic              to_disk;
        logic              done;
        logic              err;
    } regs_t;

    regs_t d, q;

    logic [LEN_W-1:0] split_len;
    logic             bo_load, bo_done;
    logic             fin, fin_err;
    logic [CNT_W-1:0] desc_cnt;
    logic [CMD_W-1:0] desc_cnt_x;
    logic [CMD_W-1:0] cmd_after;
    logic [LEN_W:0]   frac_sum;

    prd_page_split #(.PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W)) u_split (
        .addr_i (q.addr),
        .left_i (q.left),
        .len_o  (split_len)
    );

    prd_backoff #(.CYCLES(BACKOFF)) u_backoff (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (bo_load),
        .expired_o (bo_done)
    );

    assign desc_cnt   = mem_rdata_i[47:32];
    assign desc_cnt_x = CMD_W'(desc_cnt);
    assign cmd_after  = q.cmd_left - desc_cnt_x;
    assign frac_sum   = (LEN_W+1)'(q.frac) + (LEN_W+1)'(split_len);

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.err   = 1'b0;
        fin     = 1'b0;
        fin_err = 1'b0;
        bo_load = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st       = ST_FETCH;
                    d.ptr      = {table_base_i[31:2], 2'b00};
                    d.to_disk  = to_disk_i;
                    d.cmd_left = (nsec_i == 8'd0)
                               ? CMD_W'(MAX_SECTORS * SECTOR_BYTES)
                               : CMD_W'({nsec_i, {SEC_SH{1'b0}}});
                    d.sector   = lba_i;
                    d.frac     = '0;
                end
            end
            ST_FETCH: begin
                if (mem_busy_i) begin
                    d.st        = ST_PAUSE;
                    d.ret_burst = 1'b0;
                    bo_load     = 1'b1;
                end else begin
                    d.ptr = q.ptr + 32'(DESC_BYTES);
                    d.st  = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rvalid_i) begin
                    if (desc_cnt_x > q.cmd_left) begin
                        fin     = 1'b1;
                        fin_err = 1'b1;
                    end else begin
                        d.addr     = mem_rdata_i[31:0];
                        d.left     = desc_cnt;
                        d.eot      = mem_rdata_i[63];
                        d.cmd_left = cmd_after;
                        if (desc_cnt != '0) begin
                            d.st = ST_BURST;
                        end else if (mem_rdata_i[63]) begin
                            fin     = 1'b1;
                            fin_err = (cmd_after != '0);
                        end else begin
                            d.st = ST_FETCH;
                        end
                    end
                end
            end
            ST_BURST: begin
                if (mem_busy_i) begin
                    d.st        = ST_PAUSE;
                    d.ret_burst = 1'b1;
                    bo_load     = 1'b1;
                end else begin
                    d.addr   = q.addr + 32'(split_len);
                    d.left   = q.left - CNT_W'(split_len);
                    d.sector = q.sector + SEC_W'(frac_sum >> SEC_SH);
                    d.frac   = frac_sum[SEC_SH-1:0];
                    if (q.left == CNT_W'(split_len)) begin
                        if (q.eot) begin
                            fin     = 1'b1;
                            fin_err = (q.cmd_left != '0);
                        end else begin
                            d.st = ST_FETCH;
                        end
                    end
                end
            end
            ST_PAUSE: begin
                if (bo_done)
                    d.st = q.ret_burst ? ST_BURST : ST_FETCH;
            end
            default: d.st = ST_IDLE;
        endcase
        if (abort_i && q.st != ST_IDLE) begin
            fin     = 1'b1;
            fin_err = 1'b1;
        end
        if (fin) begin
            d.st   = ST_IDLE;
            d.done = 1'b1;
            d.err  = fin_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy_o     = (q.st != ST_IDLE);
    assign done_o     = q.done;
    assign err_o      = q.err;
    assign sector_o   = q.sector;
    assign mem_req_o  = (q.st == ST_FETCH || q.st == ST_BURST) && !abort_i;
    assign mem_desc_o = (q.st == ST_FETCH);
    assign mem_we_o   = (q.st == ST_BURST) && !q.to_disk;
    assign mem_addr_o = (q.st == ST_FETCH) ? q.ptr : q.addr;
    assign mem_len_o  = (q.st == ST_FETCH) ? LEN_W'(DESC_BYTES) : split_len;

    // R4
    backoff_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_busy_i |=> !mem_req_o);

    // R3
    page_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_desc_o |->
        ((LEN_W+1)'(mem_addr_o[OFF_W-1:0]) + (LEN_W+1)'(mem_len_o)) <= (LEN_W+1)'(PAGE_BYTES));

    // R3
    burst_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_desc_o |-> mem_len_o != '0);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R1
    start_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R2
    fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_desc_o |-> mem_addr_o[1:0] == 2'b00);

    // R5
    fetch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_desc_o |-> !mem_we_o);

    // R9
    abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i && busy_o |=> done_o && err_o && !busy_o);

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !busy_o && !done_o);
endmodule

// File: tb/test_prd_dma_engine.sv
module test_prd_dma_engine;
    localparam int PAGE    = 4096;
    localparam int BACKOFF = 6;
    localparam int SEC_W   = 28;
    localparam int LEN_W   = $clog2(PAGE) + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [31:0]      table_base = '0;
    logic             to_disk = 1'b0;
    logic [7:0]       nsec = '0;
    logic [SEC_W-1:0] lba = '0;
    logic             abort = 1'b0;
    logic             busy, done, err;
    logic [SEC_W-1:0] sector;
    logic             mem_req, mem_desc, mem_we;
    logic [31:0]      mem_addr;
    logic [LEN_W-1:0] mem_len;
    logic             mem_busy = 1'b0;
    logic             mem_rvalid = 1'b0;
    logic [63:0]      mem_rdata = '0;

    prd_dma_engine #(.PAGE_BYTES(PAGE), .BACKOFF(BACKOFF), .SEC_W(SEC_W)) i_prd_dma_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start), .table_base_i(table_base),
        .to_disk_i(to_disk), .nsec_i(nsec), .lba_i(lba), .abort_i(abort),
        .busy_o(busy), .done_o(done), .err_o(err), .sector_o(sector),
        .mem_req_o(mem_req), .mem_desc_o(mem_desc), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_len_o(mem_len), .mem_busy_i(mem_busy),
        .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
    );

    always #2 clk = ~clk;

    int checks = 0, fails = 0;
    longint cyc = 0;
    int busy_pct = 0;
    longint bytes_seen = 0, bursts_seen = 0, reqs_seen = 0, done_cnt = 0;
    logic last_err = 1'b0;
    logic [SEC_W-1:0] last_sec = '0;
    logic [31:0] tb_base = '0, exp_ptr = '0, e_addr = '0, rej_addr = '0;
    longint e_left = 0;
    logic exp_we = 1'b0;
    bit pending_gap = 1'b0;
    longint last_rej = 0;
    int resp_cnt = 0;
    logic [3:0] resp_idx = '0;
    logic [31:0] d_base [16];
    logic [15:0] d_cnt [16];
    logic        d_eot [16];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint exp_len(input logic [31:0] a, input longint left);
        longint room = PAGE - (a % PAGE);
        longint cap  = (left < PAGE) ? left : PAGE;
        return (cap < room) ? cap : room;
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    endtask

    // memory model and monitor, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            mem_rvalid = 1'b0;
            if (resp_cnt > 0) begin
                resp_cnt--;
                if (resp_cnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata = {d_eot[resp_idx], 15'd0, d_cnt[resp_idx], d_base[resp_idx]};
                end
            end
            if (done) begin
                done_cnt++;
                last_err = err;
                last_sec = sector;
            end
            if (mem_req) begin
                reqs_seen++;
                if (pending_gap) begin
                    chk(cyc - last_rej == BACKOFF + 1, "R4 gap", cyc - last_rej, BACKOFF + 1);
                    chk(mem_addr == rej_addr, "R4 retry addr", mem_addr, rej_addr);
                    pending_gap = 1'b0;
                end
                if (busy_pct > 0 && int'($urandom % 100) < busy_pct) begin
                    mem_busy = 1'b1;
                    pending_gap = 1'b1;
                    last_rej = cyc;
                    rej_addr = mem_addr;
                end else begin
                    mem_busy = 1'b0;
                    if (mem_desc) begin
                        logic [31:0] off;
                        off = (mem_addr - tb_base) >> 3;
                        chk(mem_addr == exp_ptr, "R2 fetch addr", mem_addr, exp_ptr);
                        chk(mem_len == 8, "R2 fetch len", mem_len, 8);
                        chk(!mem_we, "R5 fetch read", mem_we, 0);
                        resp_idx = off[3:0];
                        resp_cnt = 2;
                        exp_ptr = exp_ptr + 8;
                        e_addr = d_base[off[3:0]];
                        e_left = d_cnt[off[3:0]];
                    end else begin
                        longint l;
                        l = exp_len(e_addr, e_left);
                        chk(mem_addr == e_addr, "R3 burst addr", mem_addr, e_addr);
                        chk(mem_len == l, "R3 burst len", mem_len, l);
                        chk(mem_we == exp_we, "R5 direction", mem_we, exp_we);
                        e_addr = e_addr + 32'(mem_len);
                        e_left = e_left - mem_len;
                        bytes_seen += mem_len;
                        bursts_seen++;
                    end
                end
            end else begin
                mem_busy = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    task automatic set_desc(input int i, input logic [31:0] b, input logic [15:0] c, input logic e);
        d_base[i] = b;
        d_cnt[i]  = c;
        d_eot[i]  = e;
    endtask

    // poke > 0: a second start with other settings this many cycles in
    task automatic run_cmd(input logic [31:0] base, input bit dir, input logic [7:0] ns,
                           input logic [SEC_W-1:0] l, input int poke);
        longint n0;
        @(posedge clk); #1;
        tb_base = base & ~32'h3;
        exp_ptr = tb_base;
        exp_we = !dir;
        bytes_seen = 0;
        bursts_seen = 0;
        pending_gap = 1'b0;
        n0 = done_cnt;
        start = 1'b1; table_base = base; to_disk = dir; nsec = ns; lba = l;
        @(posedge clk); #1;
        start = 1'b0;
        if (poke > 0) begin
            repeat (poke) @(posedge clk);
            #1;
            start = 1'b1; table_base = 32'h0099_0000; to_disk = !dir; nsec = 8'd1; lba = '0;
            @(posedge clk); #1;
            start = 1'b0;
        end
        while (done_cnt == n0) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) set_desc(i, '0, '0, 1'b1);
        repeat (3) @(negedge clk);
        chk(!busy, "R10 busy", busy, 0);
        chk(!done, "R10 done", done, 0);
        chk(!mem_req, "R10 req", mem_req, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // page-straddling descriptor, unaligned table base
        set_desc(0, 32'h0000_2F00, 16'd1024, 1'b1);
        run_cmd(32'h0000_1003, 1'b1, 8'd2, 28'd100, 0);
        chk(last_err == 0, "R7 err", last_err, 0);
        chk(bursts_seen == 2, "R3 split count", bursts_seen, 2);
        chk(bytes_seen == 1024, "R6 bytes", bytes_seen, 1024);
        chk(last_sec == 102, "R6 sector", last_sec, 102);
        chk(!busy, "R7 idle", busy, 0);

        // two descriptors, half of requests refused, disk read
        busy_pct = 50;
        set_desc(0, 32'h0000_5000, 16'd2048, 1'b0);
        set_desc(1, 32'h0000_7E00, 16'd2048, 1'b1);
        run_cmd(32'h0004_0000, 1'b0, 8'd8, 28'd7, 0);
        chk(last_err == 0, "R7 err", last_err, 0);
        chk(bursts_seen == 3, "R3 split count", bursts_seen, 3);
        chk(last_sec == 15, "R6 sector", last_sec, 15);

        // sector count 0 means 256 sectors; a start while busy is ignored
        busy_pct = 20;
        for (int i = 0; i < 4; i++)
            set_desc(i, 32'h0010_0000 + 32'(i) * 32'h8000, 16'h8000, i == 3);
        run_cmd(32'h0000_0200, 1'b1, 8'd0, 28'd1000, 12);
        chk(last_err == 0, "R6 zero count err", last_err, 0);
        chk(bytes_seen == 131072, "R6 zero count bytes", bytes_seen, 131072);
        chk(last_sec == 1256, "R6 zero count sector", last_sec, 1256);
        chk(bursts_seen == 32, "R1 start while busy ignored", bursts_seen, 32);

        // oversized descriptor
        busy_pct = 0;
        set_desc(0, 32'h0000_3000, 16'd1024, 1'b1);
        run_cmd(32'h0000_0100, 1'b1, 8'd1, 28'd5, 0);
        chk(last_err == 1, "R8 err", last_err, 1);
        chk(bursts_seen == 0, "R8 no bursts", bursts_seen, 0);

        // end of table too early
        set_desc(0, 32'h0000_3000, 16'd512, 1'b1);
        run_cmd(32'h0000_0100, 1'b0, 8'd4, 28'd50, 0);
        chk(last_err == 1, "R7 early end err", last_err, 1);
        chk(last_sec == 51, "R7 early end sector", last_sec, 51);

        // zero-length descriptor
        set_desc(0, 32'h0000_6000, 16'd0, 1'b0);
        set_desc(1, 32'h0000_6100, 16'd512, 1'b1);
        run_cmd(32'h0000_0100, 1'b1, 8'd1, 28'd9, 0);
        chk(last_err == 0, "R11 err", last_err, 0);
        chk(bytes_seen == 512, "R11 bytes", bytes_seen, 512);
        chk(bursts_seen == 1, "R11 bursts", bursts_seen, 1);

        // abort while every request is refused
        begin
            longint n0, r0;
            busy_pct = 100;
            set_desc(0, 32'h0000_0000, 16'd512, 1'b1);
            @(posedge clk); #1;
            tb_base = 32'h0000_0400; exp_ptr = tb_base; pending_gap = 1'b0;
            n0 = done_cnt;
            start = 1'b1; table_base = 32'h0000_0400; nsec = 8'd1; to_disk = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
            repeat (20) @(posedge clk);
            #1;
            abort = 1'b1;
            @(posedge clk); #1;
            abort = 1'b0;
            busy_pct = 0;
            @(negedge clk); @(negedge clk);
            chk(done_cnt == n0 + 1, "R9 abort done", done_cnt, n0 + 1);
            chk(last_err == 1, "R9 abort err", last_err, 1);
            r0 = reqs_seen;
            repeat (10) @(negedge clk);
            chk(reqs_seen == r0, "R9 no request after abort", reqs_seen, r0);
            @(posedge clk); #1;
            abort = 1'b1;
            @(posedge clk); #1;
            abort = 1'b0;
            repeat (3) @(negedge clk);
            chk(done_cnt == n0 + 1, "R9 idle abort ignored", done_cnt, n0 + 1);
            chk(!busy, "R9 idle abort busy", busy, 0);
        end

        // random tables with refused requests
        void'($urandom(32'd1234));
        busy_pct = 30;
        for (int it = 0; it < 8; it++) begin
            int ns, nd, rem;
            logic [SEC_W-1:0] l0;
            ns = 1 + int'($urandom % 8);
            nd = 1 + int'($urandom % 3);
            if (nd > ns) nd = ns;
            rem = ns;
            for (int i = 0; i < nd; i++) begin
                int s;
                s = (i == nd - 1) ? rem : 1 + int'($urandom % (rem - (nd - 1 - i)));
                rem -= s;
                set_desc(i, $urandom & 32'h0003_FF00, 16'(s * 512), i == nd - 1);
            end
            l0 = SEC_W'($urandom & 32'hF_FFFF);
            run_cmd(($urandom & 32'h00FF_FFF0) | ($urandom % 4), 1'($urandom % 2),
                    8'(ns), l0, 0);
            chk(last_err == 0, "R7 random err", last_err, 0);
            chk(bytes_seen == ns * 512, "R3 random bytes", bytes_seen, ns * 512);
            chk(last_sec == l0 + SEC_W'(ns), "R6 random sector", last_sec, l0 + SEC_W'(ns));
        end

        summary();
    end
endmodule